// File: doc/BRIEF.md
# Bit-Masked GPIO Port Register Block

This block is the register front end of a 32-pin general-purpose I/O port. It keeps an output-level register and a direction register, drives the pin output value and the pin output enable from them, and brings the pin inputs back through a two-flop synchronizer so that software can read the live pin levels. A read-only identifier word lets software recognise the block.

Each 32-bit control register is seen on the bus as two word addresses, the lower one for bits 15:0 and the next one for bits 31:16. A write does not replace a whole half: the upper 16 bits of the write data form a bit-enable mask for the lower 16 data bits. Software can therefore set or clear one pin without first reading the register, and two agents sharing the port cannot undo each other's changes.

The bus is a plain single-cycle interface with byte addresses. An access happens on every rising clock edge where `bus_sel` is high. Read data is registered: it appears on `bus_rdata` after the edge that performed the read and holds until the next read.

Top module: `gpio_wm_port`

## Requirements
- R1: After reset the output-level and direction registers are all zero, so `pin_out` and `pin_oe` are 0 and every pin is an input; `bus_rdata` is 0.
- R2: On a write to a control-register half, bits 31:16 of `bus_wdata` enable bits 15:0: a register bit takes the new data bit only where its enable is 1 and keeps its value elsewhere; a write with all enables 0 changes nothing.
- R3: Byte offset 0x00 holds bits 15:0 and 0x04 holds bits 31:16 of the output-level register; 0x08 and 0x0C hold the same halves of the direction register; a write to one half leaves the other half unchanged.
- R4: A read of any control-register half returns its 16 bits in `bus_rdata[15:0]`, with `bus_rdata[31:16]` zero, after the edge that performs the read.
- R5: `pin_oe` equals the direction register: a bit of 1 makes that pin an output, 0 an input; it changes only after a write to offset 0x08 or 0x0C.
- R6: `pin_out` equals the output-level register and changes only after a write to offset 0x00 or 0x04.
- R7: A read of offset 0x70 returns the synchronized level of all 32 pins in one word; writes to 0x70 have no effect.
- R8: A read of offset 0x78 returns 0x01000C2B; writes to it have no effect.
- R9: Reads of any other offset, including addresses that are not word aligned, return 0, and writes to them change no register.
- R10: A pin input change made before clock edge E1 is not visible in a read performed at E1 or E2, and is visible in a read performed at E3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per edge while high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data: 31:16 bit enables, 15:0 data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Raw pin levels from the pads |
| pin_out | output | 32 | Pin output levels |
| pin_oe | output | 32 | Pin output enables, 1 = drive |

## Verification
A wrong bit in the output-level or direction register shows on `pin_out` or `pin_oe` right after the edge of the faulty write, so the bench compares both buses after every write in addition to reading back. A broken enable mask or half decode is visible one cycle later in the read data of the neighbouring bits or the other half. A wrong synchronizer depth shows as the pin level arriving one read early or late, which the latency test pins to an exact edge.

// File: rtl/gpio_wm_pkg.sv
package gpio_wm_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int HALF_W = 16;

  localparam logic [ADDR_W-1:0] OFF_LEVEL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DIR   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_PINS  = 8'h70;
  localparam logic [ADDR_W-1:0] OFF_IDENT = 8'h78;
  localparam logic [DATA_W-1:0] IDENT_VAL = 32'h01000C2B;

  // Byte address of half h of a split register starting at base.
  function automatic logic [ADDR_W-1:0] half_addr(logic [ADDR_W-1:0] base, int h);
    return base + ADDR_W'(4 * h);
  endfunction
endpackage

// File: rtl/gpio_wm_half_reg.sv
module gpio_wm_half_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wen,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (we) q <= (q & ~wen) | (wdata & wen);
  end
endmodule

// File: rtl/gpio_wm_sync.sv
module gpio_wm_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_wm_readback.sv
module gpio_wm_readback
  import gpio_wm_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  level_q,
  input  logic [NPINS-1:0]  dir_q,
  input  logic [NPINS-1:0]  pins_q,
  output logic [DATA_W-1:0] rd
);
  localparam int NHALF = NPINS / HALF_W;

  always_comb begin
    rd = '0;
    for (int h = 0; h < NHALF; h++) begin
      if (addr == half_addr(OFF_LEVEL, h)) rd = DATA_W'(level_q[h*HALF_W +: HALF_W]);
      if (addr == half_addr(OFF_DIR, h))   rd = DATA_W'(dir_q[h*HALF_W +: HALF_W]);
    end
    if (addr == OFF_PINS)  rd = DATA_W'(pins_q);
    if (addr == OFF_IDENT) rd = IDENT_VAL;
  end
endmodule

// File: rtl/gpio_wm_port.sv
module gpio_wm_port
  import gpio_wm_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);
  localparam int NHALF = NPINS / HALF_W;

  logic             wr_cycle;
  logic             rd_cycle;
  logic [NPINS-1:0] level_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] pins_q;
  logic [DATA_W-1:0] rd_mux;

  assign wr_cycle = bus_sel && bus_wr;
  assign rd_cycle = bus_sel && !bus_wr;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    gpio_wm_half_reg #(.W(HALF_W)) level_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_cycle && (bus_addr == half_addr(OFF_LEVEL, h))),
      .wdata (bus_wdata[HALF_W-1:0]),
      .wen   (bus_wdata[DATA_W-1:HALF_W]),
      .q     (level_q[h*HALF_W +: HALF_W])
    );
    gpio_wm_half_reg #(.W(HALF_W)) dir_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_cycle && (bus_addr == half_addr(OFF_DIR, h))),
      .wdata (bus_wdata[HALF_W-1:0]),
      .wen   (bus_wdata[DATA_W-1:HALF_W]),
      .q     (dir_q[h*HALF_W +: HALF_W])
    );
  end

  gpio_wm_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pins_q)
  );

  gpio_wm_readback #(.NPINS(NPINS)) rb_i (
    .addr    (bus_addr),
    .level_q (level_q),
    .dir_q   (dir_q),
    .pins_q  (pins_q),
    .rd      (rd_mux)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd_cycle) bus_rdata <= rd_mux;
  end

  assign pin_out = level_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_wm_port_chk.sv
module gpio_wm_port_chk
  import gpio_wm_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe
);
  logic wr_lvl_lo, wr_dir_any, wr_lvl_any, rd_half, rd_ident, rd_unmapped;

  assign wr_lvl_lo   = bus_sel && bus_wr && (bus_addr == OFF_LEVEL);
  assign wr_lvl_any  = bus_sel && bus_wr && (bus_addr == OFF_LEVEL || bus_addr == OFF_LEVEL + 8'd4);
  assign wr_dir_any  = bus_sel && bus_wr && (bus_addr == OFF_DIR || bus_addr == OFF_DIR + 8'd4);
  assign rd_half     = bus_sel && !bus_wr && (bus_addr[7:4] == 4'h0) && (bus_addr[1:0] == 2'b00);
  assign rd_ident    = bus_sel && !bus_wr && (bus_addr == OFF_IDENT);
  assign rd_unmapped = bus_sel && !bus_wr && !(bus_addr[7:4] == 4'h0 && bus_addr[1:0] == 2'b00)
                       && bus_addr != OFF_PINS && bus_addr != OFF_IDENT;

  AST_MASKED_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lvl_lo |=> pin_out[15:0] == (($past(pin_out[15:0]) & ~$past(bus_wdata[31:16]))
                                  | ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16])))); // R2
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_half |=> bus_rdata[31:16] == 16'h0); // R4
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir_any |=> $stable(pin_oe)); // R5
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lvl_any |=> $stable(pin_out)); // R6
  AST_IDENT_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ident |=> bus_rdata == IDENT_VAL); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |=> bus_rdata == '0); // R9
endmodule

bind gpio_wm_port gpio_wm_port_chk #(.NPINS(NPINS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/gpio_wm_port_tb.sv
module gpio_wm_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk; // 50 MHz

  gpio_wm_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {write, addr, wdata, expected read data}
  localparam int NV = 22;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'hFFFF_A5A5, 32'h0},           // R2 full-enable write
    {1'b0, 8'h00, 32'h0,         32'h0000_A5A5},   // R4
    {1'b1, 8'h00, 32'h00F0_0F0F, 32'h0},           // R2 only bits 7:4
    {1'b0, 8'h00, 32'h0,         32'h0000_A505},   // R2
    {1'b1, 8'h04, 32'hFFFF_1234, 32'h0},           // R3 upper half
    {1'b0, 8'h04, 32'h0,         32'h0000_1234},   // R3
    {1'b0, 8'h00, 32'h0,         32'h0000_A505},   // R3 lower half kept
    {1'b1, 8'h08, 32'h0003_FFFF, 32'h0},           // R5
    {1'b1, 8'h0C, 32'h8000_FFFF, 32'h0},           // R5
    {1'b0, 8'h08, 32'h0,         32'h0000_0003},   // R5
    {1'b0, 8'h0C, 32'h0,         32'h0000_8000},   // R5
    {1'b1, 8'h04, 32'h0000_FFFF, 32'h0},           // R2 no enables
    {1'b0, 8'h04, 32'h0,         32'h0000_1234},   // R2
    {1'b0, 8'h78, 32'h0,         32'h0100_0C2B},   // R8
    {1'b1, 8'h78, 32'hFFFF_0000, 32'h0},           // R8 write ignored
    {1'b0, 8'h78, 32'h0,         32'h0100_0C2B},   // R8
    {1'b0, 8'h10, 32'h0,         32'h0},           // R9
    {1'b1, 8'h14, 32'hFFFF_FFFF, 32'h0},           // R9
    {1'b0, 8'h14, 32'h0,         32'h0},           // R9
    {1'b1, 8'h02, 32'hFFFF_FFFF, 32'h0},           // R9 misaligned
    {1'b0, 8'h00, 32'h0,         32'h0000_A505},   // R9 nothing changed
    {1'b0, 8'h01, 32'h0,         32'h0}            // R9 misaligned read
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with rdata settled.
  task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pin_oe after release", pin_oe, 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][72], VEC[i][71:64], VEC[i][63:32]);
      if (!VEC[i][72]) check($sformatf("R2/R3/R4/R8/R9 vec%0d", i), bus_rdata, VEC[i][31:0]);
    end

    check("R6 pin_out", pin_out, 32'h1234_A505);
    check("R5 pin_oe", pin_oe, 32'h8000_0003);

    // R6: single-bit set in upper half seen on pins right after the write
    access(1'b1, 8'h04, 32'h0100_0100);
    check("R6 single bit set", pin_out, 32'h1334_A505);
    // R5: clear one direction bit
    access(1'b1, 8'h08, 32'h0001_0000);
    check("R5 single bit clear", pin_oe, 32'h8000_0002);

    // R7: external port read and write ignored
    pin_in = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    access(1'b0, 8'h70, 32'h0);
    check("R7 pin read", bus_rdata, 32'hDEAD_BEEF);
    access(1'b1, 8'h70, 32'hFFFF_0000);
    check("R7 write ignored pins", pin_out, 32'h1334_A505);
    access(1'b0, 8'h70, 32'h0);
    check("R7 read after write", bus_rdata, 32'hDEAD_BEEF);

    // R10: synchronizer latency
    pin_in = 32'h0F0F_1234;
    access(1'b0, 8'h70, 32'h0);
    check("R10 read at E1", bus_rdata, 32'hDEAD_BEEF);
    access(1'b0, 8'h70, 32'h0);
    check("R10 read at E2", bus_rdata, 32'hDEAD_BEEF);
    access(1'b0, 8'h70, 32'h0);
    check("R10 read at E3", bus_rdata, 32'h0F0F_1234);

    // R1: reset in the middle of operation
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset pin_out", pin_out, 32'h0);
    check("R1 mid reset pin_oe", pin_oe, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    access(1'b0, 8'h04, 32'h0);
    check("R1 upper half after reset", bus_rdata, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule